// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the slave side of a two-wire serial bus in front of an 8K x 8 byte-addressed memory. It runs on a fast system clock and oversamples the bus clock and data lines through synchronizers. From edges seen on those lines it finds Start and Stop conditions, shifts in bytes and answers each one with an acknowledge or leaves the data line released. The data line is open-drain: the block only ever asks for it to be pulled low.

A transfer opens with a control byte that carries a fixed four-bit device code, three chip-select bits and a read/write flag. A write continues with two address bytes and then any number of data bytes. Each data byte goes to an external page buffer together with its target address, and a commit pulse at the Stop tells the buffer to start its internal write cycle. A read returns bytes from the current pointer through a combinational memory read port. While the external write cycle runs, the busy input keeps the block from acknowledging anything, which lets the master poll for completion.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a Start and a rising one is a Stop. A Start at any point, even part-way through a byte, drops the current transfer and begins a new control byte.
- R2: A control byte is acknowledged only when its bits 7..4 are 1010 and its bits 3..1 equal `chip_sel_i[2:0]`. Bit 0 set means read and clear means write. On a mismatch the line stays released and the block ignores the bus until the next Start.
- R3: While `busy_i` is high, no received byte is acknowledged, the control byte included.
- R4: After a write control byte, the address high byte comes first and then the low byte. Only bits 4..0 of the high byte are used as address bits 12..8, and its bits 7..5 are ignored.
- R5: An acknowledge pulls the line low from the falling clock edge after the eighth bit until the falling edge of the ninth clock, so it is low across the whole high period of the ninth clock.
- R6: Each acknowledged data byte is presented once on `wr_valid_o`/`wr_addr_o`/`wr_data_o` at the current pointer. The pointer then steps by one in its low five bits only and wraps inside its 32-byte page. After a single-byte write, the pointer addresses the following location.
- R7: A Stop that ends a write in which at least one data byte was acknowledged raises `wr_commit_o` for one cycle. A write that carries only address bytes does not.
- R8: A read sends the byte at the pointer MSB first. Each bit is driven after a falling clock edge and held through the next high period. The pointer advances by one per byte and wraps across the full 13-bit space.
- R9: When the master does not acknowledge a read byte, the block releases the line and does not drive it again until a new Start.
- R10: During and right after reset, the line is released and no write strobe or commit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull the open-drain data line low |
| chip_sel_i | input | 3 | Strap value matched against control-byte bits 3..1 |
| busy_i | input | 1 | High while the memory's internal write cycle runs |
| rd_addr_o | output | 13 | Memory read address (current pointer) |
| rd_data_i | input | 8 | Memory read data for `rd_addr_o` |
| wr_valid_o | output | 1 | One-cycle strobe: a write byte is presented |
| wr_addr_o | output | 13 | Address of the presented write byte |
| wr_data_o | output | 8 | Presented write byte |
| wr_commit_o | output | 1 | One-cycle pulse at the Stop that ends a write with data |

## Verification
The bench runs a three-byte page write that starts two bytes below a page boundary. This shows whether the write pointer wraps inside its page or moves into the next page. It does a current-address read after that write and a random read at the last location. These show the difference between the page-limited write increment and the full-space read increment. It also sends control bytes with a wrong chip-select, a wrong device code, and a correct one while the busy input is held. This tells address filtering apart from busy blocking. A Start sent after four bits of a byte checks that a partly received byte is thrown away rather than carried into the next control byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } state_t;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } phase_t;

endpackage

// File: rtl/smb_bus_sampler.sv
module smb_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sync_q[SYNC_STAGES-1];
  assign sda_s = sda_sync_q[SYNC_STAGES-1];

  // idle bus is high, so synchronizers reset to one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_hi_o   = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/smb_addr_ptr.sv
module smb_addr_ptr #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              inc_rd_i,
  input  logic              inc_wr_i,
  input  logic [ADDR_W-9:0] hi_i,
  input  logic [7:0]        lo_i,
  output logic [ADDR_W-1:0] ptr_o
);

  logic [ADDR_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (ld_hi_i)       ptr_n = {hi_i, ptr_q[7:0]};
    else if (ld_lo_i)  ptr_n = {ptr_q[ADDR_W-1:8], lo_i};
    else if (inc_rd_i) ptr_n = ptr_q + 1'b1;
    else if (inc_wr_i) ptr_n = {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;

  // R4: the controller never asks for two pointer updates at once
  p_one_op_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_hi_i, ld_lo_i, inc_rd_i, inc_wr_i}));

  // R6: a write step stays inside the current page
  p_page_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_wr_i |=> ptr_q[ADDR_W-1:PAGE_BITS] == $past(ptr_q[ADDR_W-1:PAGE_BITS]));

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_hi_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic [2:0]        chip_sel_i,
  input  logic [7:0]        rd_data_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              sda_low_o,
  output logic              ld_hi_o,
  output logic              ld_lo_o,
  output logic              inc_rd_o,
  output logic              inc_wr_o,
  output logic [ADDR_W-9:0] hi_bits_o,
  output logic [7:0]        lo_bits_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o
);

  state_t            state_q, state_n;
  phase_t            phase_q, phase_n;
  logic [3:0]        bitcnt_q, bitcnt_n;
  logic [7:0]        shreg_q, shreg_n;
  logic              rw_q, rw_n;
  logic              sda_low_q, sda_low_n;
  logic              got_q, got_n;
  logic              wv_q, wv_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic [7:0]        wd_q, wd_n;
  logic              cm_q, cm_n;
  logic              addr_ok, ack_ok;

  assign addr_ok = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == chip_sel_i);
  assign ack_ok  = !busy_i && ((phase_q != PH_CTRL) || addr_ok);

  always_comb begin
    state_n   = state_q;
    phase_n   = phase_q;
    bitcnt_n  = bitcnt_q;
    shreg_n   = shreg_q;
    rw_n      = rw_q;
    sda_low_n = sda_low_q;
    got_n     = got_q;
    wv_n      = 1'b0;
    wa_n      = wa_q;
    wd_n      = wd_q;
    cm_n      = 1'b0;
    ld_hi_o   = 1'b0;
    ld_lo_o   = 1'b0;
    inc_rd_o  = 1'b0;
    inc_wr_o  = 1'b0;
    if (start_i) begin
      state_n   = ST_RX;
      phase_n   = PH_CTRL;
      bitcnt_n  = '0;
      sda_low_n = 1'b0;
      got_n     = 1'b0;
      rw_n      = 1'b0;
    end else if (stop_i) begin
      cm_n      = !rw_q && got_q;
      state_n   = ST_IDLE;
      sda_low_n = 1'b0;
      got_n     = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_n  = {shreg_q[6:0], sda_i};
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            bitcnt_n = '0;
            if (ack_ok) begin
              sda_low_n = 1'b1;
              state_n   = ST_ACK;
              case (phase_q)
                PH_CTRL: begin
                  rw_n    = shreg_q[0];
                  phase_n = shreg_q[0] ? PH_CTRL : PH_AHI;
                end
                PH_AHI: begin
                  ld_hi_o = 1'b1;
                  phase_n = PH_ALO;
                end
                PH_ALO: begin
                  ld_lo_o = 1'b1;
                  phase_n = PH_DATA;
                end
                default: begin
                  wv_n     = 1'b1;
                  wa_n     = ptr_i;
                  wd_n     = shreg_q;
                  inc_wr_o = 1'b1;
                  got_n    = 1'b1;
                end
              endcase
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_n   = ST_TX;
              shreg_n   = rd_data_i;
              inc_rd_o  = 1'b1;
              sda_low_n = ~rd_data_i[7];
            end else begin
              state_n   = ST_RX;
              sda_low_n = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bitcnt_q == 4'd8) begin
              sda_low_n = 1'b0;
              state_n   = ST_MACK;
              bitcnt_n  = '0;
            end else begin
              shreg_n   = {shreg_q[6:0], 1'b0};
              sda_low_n = ~shreg_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            if (sda_i) state_n = ST_IDLE;
          end else if (scl_fall_i) begin
            state_n   = ST_TX;
            shreg_n   = rd_data_i;
            inc_rd_o  = 1'b1;
            sda_low_n = ~rd_data_i[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_CTRL;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      rw_q      <= 1'b0;
      sda_low_q <= 1'b0;
      got_q     <= 1'b0;
      wv_q      <= 1'b0;
      wa_q      <= '0;
      wd_q      <= '0;
      cm_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      phase_q   <= phase_n;
      bitcnt_q  <= bitcnt_n;
      shreg_q   <= shreg_n;
      rw_q      <= rw_n;
      sda_low_q <= sda_low_n;
      got_q     <= got_n;
      wv_q      <= wv_n;
      wa_q      <= wa_n;
      wd_q      <= wd_n;
      cm_q      <= cm_n;
    end
  end

  assign sda_low_o  = sda_low_q;
  assign hi_bits_o  = shreg_q[ADDR_W-9:0];
  assign lo_bits_o  = shreg_q;
  assign wr_valid_o = wv_q;
  assign wr_addr_o  = wa_q;
  assign wr_data_o  = wd_q;
  assign commit_o   = cm_q;

  // R5: the drive never changes while the clock line stays high
  p_hold_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hi_i && $past(scl_hi_i) && !start_i && !stop_i) |-> $stable(sda_low_q));

  // R3: an acknowledge only follows a byte decided while not busy
  p_busy_nack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) == ST_RX) |-> !$past(busy_i));

  // R9: a released slave waiting for a Start never pulls the line
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_low_q);

  // R6: a presented write byte is always being acknowledged
  p_wr_acked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wv_q |-> sda_low_q);

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BITS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        chip_sel_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);

  localparam int HI_W = ADDR_W - 8;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic scl_hi, sda_v, scl_rise, scl_fall, start_det, stop_det;
  logic ld_hi, ld_lo, inc_rd, inc_wr;
  logic [HI_W-1:0]   hi_bits;
  logic [7:0]        lo_bits;
  logic [ADDR_W-1:0] ptr;

  smb_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_hi_o   (scl_hi),
    .sda_o      (sda_v),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_hi_i   (scl_hi),
    .sda_i      (sda_v),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .busy_i     (busy_i),
    .chip_sel_i (chip_sel_i),
    .rd_data_i  (rd_data_i),
    .ptr_i      (ptr),
    .sda_low_o  (sda_pull_o),
    .ld_hi_o    (ld_hi),
    .ld_lo_o    (ld_lo),
    .inc_rd_o   (inc_rd),
    .inc_wr_o   (inc_wr),
    .hi_bits_o  (hi_bits),
    .lo_bits_o  (lo_bits),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .commit_o   (wr_commit_o)
  );

  smb_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) ptr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .ld_hi_i  (ld_hi),
    .ld_lo_i  (ld_lo),
    .inc_rd_i (inc_rd),
    .inc_wr_i (inc_wr),
    .hi_i     (hi_bits),
    .lo_i     (lo_bits),
    .ptr_o    (ptr)
  );

  assign rd_addr_o = ptr;

endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;

  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda;
  logic        busy;
  logic [2:0]  cs;
  logic        sda_pull;
  logic        sda_line;
  logic [12:0] rd_addr;
  logic [7:0]  rd_data;
  logic        wr_valid, wr_commit;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  function automatic logic [7:0] fmem(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]};
  endfunction

  assign rd_data = fmem(rd_addr);

  serial_mem_slave dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .chip_sel_i  (cs),
    .busy_i      (busy),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit)
  );

  int checks = 0;
  int failures = 0;
  int commits = 0;
  bit done = 0;
  logic [20:0] wq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the write port against the expected byte list
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R6 unexpected write", int'({wr_addr, wr_data}), 0);
        end else begin
          logic [20:0] e;
          e = wq.pop_front();
          chk({wr_addr, wr_data} == e, "R6 write byte", int'({wr_addr, wr_data}), int'(e));
        end
      end
      if (wr_commit) commits++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(2);
    end
  endtask

  // sends a byte and returns the slave's acknowledge; checks it is held (R5)
  task automatic put_byte(input logic [7:0] b, output bit acked);
    logic a0, a1, a2;
    put_bits(b, 8);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(2);
    a0 = sda_line; tick(6);
    a1 = sda_line; tick(1);
    a2 = sda_line; tick(1);
    m_scl = 1'b0; tick(2);
    acked = !a1;
    if (acked) chk(!a0 && !a2, "R5 ack held", {a0, a2}, 0);
  endtask

  task automatic get_byte(output logic [7:0] b, input bit ack_it);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      m_scl = 1'b1; tick(H / 2);
      b = {b[6:0], sda_line}; tick(H / 2);
      m_scl = 1'b0; tick(2);
    end
    m_sda = !ack_it; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; busy = 1'b0; cs = 3'b101;
    tick(5);
    chk(!sda_pull && !wr_valid && !wr_commit, "R10 in reset", {sda_pull, wr_valid, wr_commit}, 0);
    rst_n = 1'b1;
    tick(10);
    chk(!sda_pull && !wr_valid && !wr_commit, "R10 after reset", {sda_pull, wr_valid, wr_commit}, 0);

    // page write starting two bytes below a page boundary, top address bits set
    bus_start();
    put_byte(8'hAA, a); chk(a, "R2 write control ack", a, 1);
    put_byte(8'hE1, a); chk(a, "R4 high address ack", a, 1);
    put_byte(8'h1E, a); chk(a, "R4 low address ack", a, 1);
    wq.push_back({13'h011E, 8'h5A});
    wq.push_back({13'h011F, 8'hC3});
    wq.push_back({13'h0100, 8'h77});
    put_byte(8'h5A, a); chk(a, "R6 data ack", a, 1);
    put_byte(8'hC3, a); chk(a, "R6 data ack", a, 1);
    put_byte(8'h77, a); chk(a, "R6 data ack at wrap", a, 1);
    bus_stop(); tick(5);
    chk(commits == 1, "R7 commit after write", commits, 1);

    // current-address read continues at 0x101
    bus_start();
    put_byte(8'hAB, a); chk(a, "R2 read control ack", a, 1);
    get_byte(d, 1'b1); chk(d == fmem(13'h0101), "R8 read byte 0", d, fmem(13'h0101));
    get_byte(d, 1'b0); chk(d == fmem(13'h0102), "R8 read byte 1", d, fmem(13'h0102));
    tick(H);
    chk(!sda_pull, "R9 released after master nack", sda_pull, 0);
    m_scl = 1'b1; tick(H / 2);
    chk(sda_line, "R9 line high after nack", sda_line, 1);
    m_scl = 1'b0; tick(2);
    bus_stop();

    // random read at the last location wraps across the full space
    bus_start();
    put_byte(8'hAA, a); chk(a, "R2 control ack", a, 1);
    put_byte(8'h1F, a); chk(a, "R4 high ack", a, 1);
    put_byte(8'hFF, a); chk(a, "R4 low ack", a, 1);
    bus_start();
    put_byte(8'hAB, a); chk(a, "R2 read control ack", a, 1);
    get_byte(d, 1'b1); chk(d == fmem(13'h1FFF), "R8 last location", d, fmem(13'h1FFF));
    get_byte(d, 1'b0); chk(d == fmem(13'h0000), "R8 wrap to zero", d, fmem(13'h0000));
    bus_stop(); tick(5);
    chk(commits == 1, "R7 no commit without data", commits, 1);

    // address filtering
    bus_start();
    put_byte(8'hA2, a); chk(!a, "R2 wrong chip select", a, 0);
    put_byte(8'h00, a); chk(!a, "R2 ignored until start", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'hBA, a); chk(!a, "R2 wrong device code", a, 0);
    bus_stop();

    // busy blocks every acknowledge
    busy = 1'b1;
    bus_start();
    put_byte(8'hAA, a); chk(!a, "R3 busy control nack", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte(8'hAA, a); chk(a, "R3 control ack when free", a, 1);
    busy = 1'b1;
    put_byte(8'h00, a); chk(!a, "R3 busy address nack", a, 0);
    bus_stop();
    busy = 1'b0;
    tick(5);
    chk(commits == 1, "R3 no commit while busy", commits, 1);

    // Start after half a byte restarts control reception; pointer is 0x0001
    bus_start();
    put_bits(8'hAA, 4);
    bus_start();
    put_byte(8'hAB, a); chk(a, "R1 control after restart", a, 1);
    get_byte(d, 1'b0); chk(d == fmem(13'h0001), "R1 read after restart", d, fmem(13'h0001));
    bus_stop();

    // single-byte write leaves the pointer on the next location
    bus_start();
    put_byte(8'hAA, a); chk(a, "R2 control ack", a, 1);
    put_byte(8'h00, a);
    put_byte(8'h40, a);
    wq.push_back({13'h0040, 8'h99});
    put_byte(8'h99, a); chk(a, "R6 single data ack", a, 1);
    bus_stop(); tick(5);
    chk(commits == 2, "R7 second commit", commits, 2);
    bus_start();
    put_byte(8'hAB, a);
    get_byte(d, 1'b0); chk(d == fmem(13'h0041), "R6 pointer after byte write", d, fmem(13'h0041));
    bus_stop();

    tick(20);
    chk(wq.size() == 0, "R6 all writes seen", wq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule